// File: doc/BRIEF.md
# Running Sum and Peak Tracker

This block takes in a stream of unsigned samples. A sample counts only in a cycle where the qualifier input is high. From those samples the block keeps two results side by side. The first is a running total of every accepted sample. The second is the largest sample seen since the last reset.

A select input picks which of the two results drives the one shared output. The select path is combinational, so a consumer can read either result in any cycle without disturbing the stored values. The peak path uses an unsigned magnitude comparator built as a chain of one-bit compare slices, which is checked from the most significant bit down.

Top module: `sum_peak_tracker`

## Requirements
- R1: The sample, the output and both stored values are DATA_W bits wide (default 8), and all of them are treated as unsigned.
- R2: Reset is synchronous and active-low. When `rst_n` is sampled low at a rising edge, both the sum and the peak become zero, even if `sample_en` is high in that cycle.
- R3: When `sample_en` is low at a rising edge, both the sum and the peak keep their values.
- R4: For each accepted sample, the sum becomes (sum + sample) mod 2^DATA_W. Overflow wraps with no flag.
- R5: The peak loads an accepted sample only when that sample is strictly greater than the stored peak. An equal or smaller sample leaves the peak unchanged.
- R6: The greater-than decision comes from a chain of DATA_W one-bit comparator slices ordered from the MSB down. It matches unsigned magnitude comparison for every pair of operands.
- R7: When `show_peak` = 1, `result_out` shows the peak. When `show_peak` = 0, it shows the sum. A change of `show_peak` shows on the output in the same cycle and does not alter either stored value.
- R8: The stored values, and therefore the output for a fixed `show_peak`, change only at rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset for both results |
| sample_in | input | DATA_W | Unsigned sample value |
| sample_en | input | 1 | Qualifies `sample_in` as accepted in this cycle |
| show_peak | input | 1 | 1 selects the peak, 0 selects the running sum |
| result_out | output | DATA_W | Selected result |

## Verification
The bench builds the block with DATA_W = 4. This makes the set of operands small enough to cover every (stored peak, incoming sample) pair, all 256 of them. Each of those pairs also exercises every wraparound case of the 4-bit sum. Both results are read through the select line after every step. Extra sequences cover disabled samples, reset with the qualifier high, and inputs that change away from a clock edge.

// File: rtl/sum_peak_pkg.sv
// Shared definitions for the running sum and peak tracker.
// Assumes: the result selector is a single bit; widths come from parameters.
package sum_peak_pkg;
    parameter int unsigned SPT_DEFAULT_W = 8;

    typedef enum logic {
        SEL_SUM  = 1'b0,
        SEL_PEAK = 1'b1
    } result_sel_e;
endpackage

// File: rtl/spt_cmp_slice.sv
// One bit of an MSB-first magnitude comparator.
// Assumes: gt_in/eq_in come from the more significant neighbour; the MSB slice
// receives gt_in=0, eq_in=1.
module spt_cmp_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic gt_in,
    input  logic eq_in,
    output logic gt_out,
    output logic eq_out
);
    // Purpose: extend the decision of the higher bits by this bit position.
    always_comb begin
        gt_out = gt_in | (eq_in & a_bit & ~b_bit);
        eq_out = eq_in & ~(a_bit ^ b_bit);
    end
endmodule

// File: rtl/spt_mag_cmp.sv
// Unsigned W-bit comparator made of cascaded one-bit slices (R6).
// Assumes: operands are unsigned; result is purely combinational.
module spt_mag_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b
);
    logic [W:0] gt_c;
    logic [W:0] eq_c;

    // Purpose: seed the chain at the MSB end.
    always_comb begin
        gt_c[W] = 1'b0;
        eq_c[W] = 1'b1;
    end

    for (genvar i = W - 1; i >= 0; i--) begin : g_slice
        spt_cmp_slice u_slice (
            .a_bit  (a[i]),
            .b_bit  (b[i]),
            .gt_in  (gt_c[i+1]),
            .eq_in  (eq_c[i+1]),
            .gt_out (gt_c[i]),
            .eq_out (eq_c[i])
        );
    end

    assign a_gt_b = gt_c[0];

    // Purpose: the slice chain agrees with unsigned comparison.
    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_cmp_gt_R6: assert (gt_c[0] == (a > b));
            assert_cmp_eq_R6: assert (eq_c[0] == (a == b));
        end
    end
endmodule

// File: rtl/spt_sum_reg.sv
// Running modulo-2^W sum of accepted samples.
// Assumes: synchronous active-low reset that takes priority over enable.
module spt_sum_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_q
);
    // Purpose: clear on reset, otherwise add each accepted sample with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (en)
            sum_q <= sum_q + din;
    end

    assert_sum_reset_R2: assert property (@(posedge clk)
        !rst_n |=> sum_q == '0);
    assert_sum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sum_q));
    assert_sum_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> sum_q == W'($past(sum_q) + $past(din)));
endmodule

// File: rtl/spt_peak_reg.sv
// Running maximum of accepted samples, fed by the sliced comparator.
// Assumes: unsigned samples; strict greater-than loads; reset to zero.
module spt_peak_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] peak_q
);
    logic is_bigger;

    spt_mag_cmp #(.W(W)) u_cmp (
        .a      (din),
        .b      (peak_q),
        .a_gt_b (is_bigger)
    );

    // Purpose: clear on reset, else take a strictly larger accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            peak_q <= '0;
        else if (en && is_bigger)
            peak_q <= din;
    end

    assert_peak_reset_R2: assert property (@(posedge clk)
        !rst_n |=> peak_q == '0);
    assert_peak_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (din > peak_q)) |=> peak_q == $past(din));
    assert_peak_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && (din > peak_q)) |=> $stable(peak_q));
endmodule

// File: rtl/sum_peak_tracker.sv
// Top: running sum and running peak of one qualified stream, one shared output.
// Assumes: synchronous active-low reset; combinational output selection.
module sum_peak_tracker
    import sum_peak_pkg::*;
#(
    parameter int unsigned DATA_W = SPT_DEFAULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sample_en,
    input  logic              show_peak,
    output logic [DATA_W-1:0] result_out
);
    logic [DATA_W-1:0] sum_val;
    logic [DATA_W-1:0] peak_val;
    result_sel_e       sel;

    spt_sum_reg #(.W(DATA_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_en),
        .din   (sample_in),
        .sum_q (sum_val)
    );

    spt_peak_reg #(.W(DATA_W)) u_peak (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sample_en),
        .din    (sample_in),
        .peak_q (peak_val)
    );

    // Purpose: steer the chosen result to the shared output.
    always_comb begin
        sel = result_sel_e'(show_peak);
        case (sel)
            SEL_PEAK: result_out = peak_val;
            default:  result_out = sum_val;
        endcase
    end

    assert_peak_not_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> peak_val >= $past(sample_in));
endmodule

// File: tb/test_sum_peak_tracker.sv
module test_sum_peak_tracker;
    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic         sample_en = 1'b0;
    logic         show_peak = 1'b0;
    logic [W-1:0] result_out;

    int n_checks = 0;
    int n_fail = 0;
    int exp_sum = 0;
    int exp_peak = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sum_peak_tracker #(.DATA_W(W)) i_sum_peak_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .sample_en  (sample_en),
        .show_peak  (show_peak),
        .result_out (result_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7: read both results through the selector, away from any edge.
    task automatic read_both(input string req);
        show_peak = 1'b0; #1;
        check({req, " R7 sum"}, int'(result_out), exp_sum);
        show_peak = 1'b1; #1;
        check({req, " R7 peak"}, int'(result_out), exp_peak);
    endtask

    // Drive at falling edge, update the model at the rising edge.
    task automatic step(input bit rn, input bit en, input int d);
        @(negedge clk);
        rst_n = rn; sample_en = en; sample_in = W'(d);
        @(posedge clk); #1;
        if (!rn) begin
            exp_sum = 0; exp_peak = 0;
        end else if (en) begin
            exp_sum = (exp_sum + d) % N;
            if (d > exp_peak) exp_peak = d;
        end
    endtask

    initial begin
        check("R1 width", $bits(result_out), W);
        step(0, 0, 0);
        read_both("R2 reset");
        // R5/R6/R4: every (stored peak, new sample) pair, sum wraps included.
        for (int p = 0; p < N; p++) begin
            for (int s = 0; s < N; s++) begin
                step(0, 0, 0);
                step(1, 1, p);
                step(1, 1, s);
                read_both("R4 R5 R6 pair");
            end
        end
        // R3: disabled samples change nothing.
        step(0, 0, 0);
        step(1, 1, 9);
        for (int k = 0; k < N; k++) begin
            step(1, 0, k);
            read_both("R3 hold");
        end
        // R2: reset wins over enable.
        step(1, 1, 7);
        step(0, 1, 15);
        read_both("R2 priority");
        // R4: long accumulation with wraparound.
        for (int k = 0; k < 40; k++) begin
            step(1, 1, (k * 5 + 3) % N);
            read_both("R4 chain");
        end
        // R8: inputs changing between edges do not move the output.
        @(negedge clk);
        sample_en = 1'b1; sample_in = W'(15); show_peak = 1'b0;
        #1 check("R8 no edge sum", int'(result_out), exp_sum);
        sample_in = W'(2);
        #1 check("R8 no edge sum", int'(result_out), exp_sum);
        sample_en = 1'b0;
        @(posedge clk); #1;
        read_both("R8 after edge");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule